// File: doc/BRIEF.md
# Three-Lane Marker Deskew

This block lines up three symbol streams that have each been word-aligned but still arrive offset from one another by a few symbols. Every lane pushes its symbol and a one-bit marker flag into a private FIFO. The three FIFOs are drained on one shared clock. Normally every lane is read on every cycle. When a marker reaches the head of some lanes before it reaches the others, the control logic holds back the reads of the lanes that show the marker. The lagging lanes keep draining until their own marker reaches the head. From then on, all three lanes leave the block in step.

The lane writers keep writing while a lane is held, so a held lane fills up by one entry per cycle of skew. A lane that fills up and is written again has overflowed. This raises a one-cycle request back to the word aligners, empties all three FIFOs and drops the deskewed status. Status is regained only on the next marker that leaves all three lanes in the same cycle. Nothing is written and all state is cleared while word alignment is not complete.

Top module: `tri_lane_deskew`

## Requirements
- R1: After reset, sym_o, mark_o, out_valid_o, deskewed_o and realign_o are all zero.
- R2: While align_done_i is low, lane inputs are not stored. out_valid_o and deskewed_o stay low from the cycle after align_done_i is seen low.
- R3: With continuous writes on all lanes, skew of up to 8 symbols between lanes is absorbed with no overflow (realign_o stays low). realign_o is asserted only after a write hit a full lane FIFO.
- R4: A lane whose FIFO head carries a marker is not read while another lane's head has no marker. After the lanes meet at a marker, every output word carries symbols of the same index on all three lanes. When out_valid_o is high, mark_o is either 3'b000 or 3'b111.
- R5: When two lanes show a marker at their heads and the third does not, both marked lanes are held until the third lane's marker arrives.
- R6: The write of the last lane's marker happens at clock edge n. Then mark_o is 3'b111 and deskewed_o rises after edge n+1, and deskewed_o is low after edge n.
- R7: With no skew and all lanes written each cycle, a symbol written at edge n appears on sym_o with out_valid_o high after edge n+1.
- R8: A lane FIFO holds 16 entries. A write to a full lane that is not read in the same cycle raises realign_o for exactly one cycle after that edge. The same edge clears deskewed_o and empties all FIFOs, so out_valid_o is low after the next edge and high again one edge later under continuous writes.
- R9: When align_done_i falls, deskewed_o is low after the next clock edge.
- R10: Lane l occupies bits [l*SYM_W +: SYM_W] of lane_sym_i and sym_o, and bit l of lane_mark_i, lane_vld_i and mark_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared read/write clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| align_done_i | input | 1 | All lanes word-aligned; low flushes the block |
| lane_vld_i | input | 3 | Per-lane write strobe |
| lane_sym_i | input | 3*SYM_W | Aligned symbols, lane 0 in low bits |
| lane_mark_i | input | 3 | Per-lane marker flag for the symbol |
| sym_o | output | 3*SYM_W | Deskewed symbols |
| mark_o | output | 3 | Marker flags travelling with sym_o |
| out_valid_o | output | 1 | sym_o holds a word read from all lanes at once |
| deskewed_o | output | 1 | Lanes are locked to a common marker |
| realign_o | output | 1 | One-cycle request to restart word alignment |

## Verification
A symbol written at one edge is read at the next edge and registered onto the outputs by that same edge. Every output result is therefore due one edge after the write that caused it. The overflow request appears at the edge of the write that hits a full lane, 16 edges after a lone marker stalls a lane that holds one entry. The bench drives inputs on the falling edge and samples just before the next drive. It indexes each check by the drive cycle, so expected values are pinned to these exact edges. The edge before each one is also checked, so a result that comes one cycle early or late is reported.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  localparam int unsigned NUM_LANES = 3;
  typedef logic [NUM_LANES-1:0] lane_mask_t;
endpackage

// File: rtl/lane_fifo.sv
module lane_fifo #(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_i,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             mark_i,
  input  logic             rd_i,
  output logic [SYM_W-1:0] head_sym_o,
  output logic             head_mark_o,
  output logic             empty_o,
  output logic             full_o,
  output logic             ovf_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned EW = SYM_W + 1;

  logic [EW-1:0] mem_q [DEPTH];
  logic [AW:0]   wptr_q, rptr_q;
  logic          do_rd, do_wr;

  assign empty_o = (wptr_q == rptr_q);
  assign full_o  = (wptr_q[AW] != rptr_q[AW]) && (wptr_q[AW-1:0] == rptr_q[AW-1:0]);
  assign do_rd   = rd_i && !empty_o;
  assign do_wr   = wr_i && (!full_o || do_rd);
  assign ovf_o   = wr_i && full_o && !do_rd;

  assign {head_mark_o, head_sym_o} = mem_q[rptr_q[AW-1:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
    end else begin
      if (do_wr) wptr_q <= wptr_q + 1'b1;
      if (do_rd) rptr_q <= rptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_wr && !flush_i) mem_q[wptr_q[AW-1:0]] <= {mark_i, sym_i};
  end
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl #(
  parameter int unsigned NL = 3
) (
  input  logic          en_i,
  input  logic [NL-1:0] empty_i,
  input  logic [NL-1:0] head_mark_i,
  output logic [NL-1:0] rd_o,
  output logic          pop_all_o,
  output logic          all_mark_o
);
  logic [NL-1:0] mark_eff;
  logic [NL-1:0] stall;

  assign all_mark_o = &mark_eff;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    // an empty lane counts as not yet showing its marker
    assign mark_eff[l] = head_mark_i[l] && !empty_i[l];
    assign stall[l]    = en_i && mark_eff[l] && !all_mark_o;
    assign rd_o[l]     = en_i && !empty_i[l] && !stall[l];
  end

  assign pop_all_o = &rd_o;
endmodule

// File: rtl/deskew_out.sv
module deskew_out #(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned NL    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                pop_all_i,
  input  logic                all_mark_i,
  input  logic [NL*SYM_W-1:0] head_sym_i,
  input  logic [NL-1:0]       head_mark_i,
  output logic [NL*SYM_W-1:0] sym_o,
  output logic [NL-1:0]       mark_o,
  output logic                out_valid_o,
  output logic                deskewed_o
);
  logic prev_mark_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_o       <= '0;
      mark_o      <= '0;
      out_valid_o <= 1'b0;
      deskewed_o  <= 1'b0;
      prev_mark_q <= 1'b0;
    end else if (clear_i) begin
      sym_o       <= '0;
      mark_o      <= '0;
      out_valid_o <= 1'b0;
      deskewed_o  <= 1'b0;
      prev_mark_q <= 1'b0;
    end else begin
      out_valid_o <= pop_all_i;
      if (pop_all_i) begin
        sym_o       <= head_sym_i;
        mark_o      <= head_mark_i;
        prev_mark_q <= all_mark_i;
        // lock on the rising edge of a common marker
        if (all_mark_i && !prev_mark_q) deskewed_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tri_lane_deskew.sv
module tri_lane_deskew
  import deskew_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       align_done_i,
  input  logic [NUM_LANES-1:0]       lane_vld_i,
  input  logic [NUM_LANES*SYM_W-1:0] lane_sym_i,
  input  logic [NUM_LANES-1:0]       lane_mark_i,
  output logic [NUM_LANES*SYM_W-1:0] sym_o,
  output logic [NUM_LANES-1:0]       mark_o,
  output logic                       out_valid_o,
  output logic                       deskewed_o,
  output logic                       realign_o
);
  localparam int unsigned BUS_W = NUM_LANES * SYM_W;

  lane_mask_t       rd_w, empty_w, full_w, ovf_w, head_mark_w;
  logic [BUS_W-1:0] head_sym_w;
  logic             pop_all_w, all_mark_w, ovf_any, flush_w;

  assign ovf_any = |ovf_w;
  assign flush_w = ovf_any || !align_done_i;

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    lane_fifo #(.SYM_W(SYM_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (flush_w),
      .wr_i        (lane_vld_i[l] && align_done_i),
      .sym_i       (lane_sym_i[l*SYM_W +: SYM_W]),
      .mark_i      (lane_mark_i[l]),
      .rd_i        (rd_w[l]),
      .head_sym_o  (head_sym_w[l*SYM_W +: SYM_W]),
      .head_mark_o (head_mark_w[l]),
      .empty_o     (empty_w[l]),
      .full_o      (full_w[l]),
      .ovf_o       (ovf_w[l])
    );
  end

  deskew_ctrl #(.NL(NUM_LANES)) u_ctrl (
    .en_i        (align_done_i),
    .empty_i     (empty_w),
    .head_mark_i (head_mark_w),
    .rd_o        (rd_w),
    .pop_all_o   (pop_all_w),
    .all_mark_o  (all_mark_w)
  );

  deskew_out #(.SYM_W(SYM_W), .NL(NUM_LANES)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (flush_w),
    .pop_all_i   (pop_all_w),
    .all_mark_i  (all_mark_w),
    .head_sym_i  (head_sym_w),
    .head_mark_i (head_mark_w),
    .sym_o       (sym_o),
    .mark_o      (mark_o),
    .out_valid_o (out_valid_o),
    .deskewed_o  (deskewed_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) realign_o <= 1'b0;
    else         realign_o <= ovf_any;
  end
endmodule

// File: rtl/tri_lane_deskew_chk.sv
module tri_lane_deskew_chk #(
  parameter int unsigned NL = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          align_done_i,
  input logic [NL-1:0] mark_o,
  input logic          out_valid_o,
  input logic          deskewed_o,
  input logic          realign_o,
  input logic [NL-1:0] full_w
);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !align_done_i |=> (!out_valid_o && !deskewed_o));

  a_r3_realign_needs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(realign_o) |-> $past(|full_w));

  a_r4_marks_whole: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (mark_o == '0 || mark_o == '1));

  a_r6_lock_on_marker: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(deskewed_o) |-> (out_valid_o && mark_o == '1));

  a_r8_realign_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |=> !realign_o);

  a_r8_realign_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    realign_o |-> (!deskewed_o && !out_valid_o));
endmodule

bind tri_lane_deskew tri_lane_deskew_chk #(.NL(3)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .align_done_i (align_done_i),
  .mark_o       (mark_o),
  .out_valid_o  (out_valid_o),
  .deskewed_o   (deskewed_o),
  .realign_o    (realign_o),
  .full_w       (full_w)
);

// File: tb/tri_lane_deskew_bench.sv
module tri_lane_deskew_bench;
  localparam int SYM_W = 10;
  localparam int MK    = 12;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               align_done;
  logic [2:0]         vld, mk_in;
  logic [3*SYM_W-1:0] sym_in, sym_out;
  logic [2:0]         mark_out;
  logic               out_valid, deskewed, realign;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tri_lane_deskew #(.SYM_W(SYM_W), .DEPTH(16)) u_tri_lane_deskew (
    .clk_i(clk), .rst_ni(rst_n), .align_done_i(align_done),
    .lane_vld_i(vld), .lane_sym_i(sym_in), .lane_mark_i(mk_in),
    .sym_o(sym_out), .mark_o(mark_out), .out_valid_o(out_valid),
    .deskewed_o(deskewed), .realign_o(realign)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [SYM_W-1:0] enc(input int lane, input int k);
    logic [1:0] ln;
    logic [7:0] kk;
    ln = lane[1:0];
    kk = k[7:0];
    return {ln, kk};
  endfunction

  function automatic int out_k(input int lane);
    return int'(sym_out[lane*SYM_W +: 8]);
  endfunction

  // drive one cycle at the falling edge, return at the next falling edge
  task automatic tick(input bit al, input logic [2:0] mk, input int k0, input int k1, input int k2);
    align_done = al;
    vld        = 3'b111;
    mk_in      = mk;
    sym_in     = {enc(2, k2), enc(1, k1), enc(0, k0)};
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; align_done = 1'b0; vld = '0; mk_in = '0; sym_in = '0;
    repeat (2) @(negedge clk);
    chk(sym_out == '0 && mark_out == '0, "R1 data", int'(mark_out), 0);
    chk(!out_valid && !deskewed && !realign, "R1 flags",
        int'({out_valid, deskewed, realign}), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_idle;
    for (int i = 0; i < 10; i++) begin
      tick(1'b0, 3'b111, i, i, i);
      chk(!out_valid && !deskewed, "R2 no output before alignment",
          int'({out_valid, deskewed}), 0);
    end
  endtask

  task automatic t_latency;
    tick(1'b0, 3'b000, 0, 0, 0);
    for (int i = 0; i < 8; i++) begin
      tick(1'b1, 3'b000, i, i, i);
      if (i >= 1) begin
        chk(out_valid, "R7 valid", int'(out_valid), 1);
        chk(out_k(0) == i - 1 && out_k(1) == i - 1 && out_k(2) == i - 1,
            "R7 R10 one-edge latency", out_k(2), i - 1);
        chk(sym_out[2*SYM_W+8 +: 2] == 2'd2, "R10 lane placement",
            int'(sym_out[2*SYM_W+8 +: 2]), 2);
      end
    end
  endtask

  task automatic t_skew(input int d0, input int d1, input int d2, input string req);
    int dm, il;
    int dd[3];
    logic [2:0] m;
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    dm = d0; if (d1 > dm) dm = d1; if (d2 > dm) dm = d2;
    il = MK + dm;
    tick(1'b0, 3'b000, 0, 0, 0);
    for (int i = 0; i < il + 12; i++) begin
      for (int l = 0; l < 3; l++) m[l] = (i - dd[l] == MK);
      tick(1'b1, m, i - d0, i - d1, i - d2);
      chk(!realign, {req, " R3 no overflow"}, int'(realign), 0);
      if (i == il) chk(!deskewed, {req, " R6 not early"}, int'(deskewed), 0);
      if (i == il + 1) begin
        chk(deskewed && mark_out == 3'b111, {req, " R6 lock"},
            int'({deskewed, mark_out}), 15);
        chk(out_k(0) == MK && out_k(1) == MK && out_k(2) == MK,
            {req, " R4 marker word"}, out_k(0), MK);
      end
      if (i > il + 1)
        chk(out_valid && out_k(0) == i - 1 - dm && out_k(1) == i - 1 - dm &&
            out_k(2) == i - 1 - dm, {req, " R4 lanes in step"}, out_k(0), i - 1 - dm);
    end
  endtask

  task automatic t_drop;
    tick(1'b0, 3'b000, 0, 0, 0);
    chk(!deskewed, "R9 status drop", int'(deskewed), 0);
  endtask

  task automatic t_overflow;
    int i0;
    logic [2:0] m;
    i0 = MK + 5;
    tick(1'b0, 3'b000, 0, 0, 0);
    for (int i = 0; i <= i0 + 18; i++) begin
      m = (i == MK) ? 3'b111 : (i == i0) ? 3'b001 : 3'b000;
      tick(1'b1, m, i, i, i);
      if (i == MK + 3) chk(deskewed, "R8 locked before", int'(deskewed), 1);
      if (i == i0 + 15) chk(!realign, "R8 not early", int'(realign), 0);
      if (i == i0 + 16) begin
        chk(realign, "R8 realign", int'(realign), 1);
        chk(!deskewed, "R8 status cleared", int'(deskewed), 0);
      end
      if (i == i0 + 17) begin
        chk(!realign, "R8 one-cycle pulse", int'(realign), 0);
        chk(!out_valid, "R8 flushed", int'(out_valid), 0);
      end
      if (i == i0 + 18) chk(out_valid, "R8 restart", int'(out_valid), 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_latency();
    t_skew(0, 0, 0, "R4 zero skew");
    t_skew(0, 0, 5, "R5 two early lanes");
    t_skew(8, 0, 3, "R3 max skew");
    t_skew(2, 7, 0, "R4 mixed skew");
    t_drop();
    t_overflow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule